// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block turns one 32-bit command word into a clause-22 management transaction on the MDC/MDIO pair. The host writes the command through a strobe. If the block is idle and the management port is enabled, the block latches the word. It first sends a 32-bit run of ones, then shifts out the 32 command bits, most significant first. For a read, it releases MDIO during the turnaround and captures the 16 data bits the PHY returns into the low half of the same command register. An idle flag tells the host when the register can be read back and a new command issued.

MDC runs only during a frame. Its period is the system clock divided by 8, 16, 32 or 64, selected by a 2-bit input. Each bit time starts with MDC low. The controller changes MDIO at the start of the bit time, which is the falling edge of MDC, and samples returned data on the rising edge in the middle of the bit.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and the command register reads 0.
- R2: A cmd_wr pulse while idle and mgmt_en is 1 loads cmd_wdata into the command register and starts a frame. From the next cycle, idle is 0.
- R3: One MDC period is N = 8 << div_sel system clocks. MDC is low for the first N/2 clocks of each bit time and high for the last N/2. MDC stays low while idle.
- R4: The first 32 bit times of a frame drive MDIO high with mdio_oe set.
- R5: The next 32 bit times drive command register bits 31 down to 0 in that order, one per bit time.
- R6: When register bits 29:28 equal 2'b10 (read), mdio_oe is 0 from the bit time that carries register bit 16 until the end of the frame. Any other value of these bits drives all 32 bits.
- R7: On a read, MDIO is sampled on the MDC rising edge of each of the last 16 bit times. The samples, first one as bit 15, replace register bits 15:0. Bits 31:16 are unchanged.
- R8: idle rises, and mdio_oe and mdc fall, exactly 64*N clocks after the accepting edge. For a write, the register still holds the command.
- R9: A cmd_wr pulse while a frame is in progress has no effect on the frame or on the register.
- R10: While mgmt_en is 0, cmd_wr is ignored. Clearing mgmt_en during a frame ends it at the next edge, with idle 1, mdc 0 and mdio_oe 0.
- R11: div_sel is captured when a frame starts. Changing it during the frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC divisor select: 8, 16, 32, 64 |
| cmd_rdata | output | 32 | Command register contents, including returned read data |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO input value |
| idle | output | 1 | High when no frame is in progress |

## Verification
Every result is tied to the accepting clock edge k. With h = N/2:
- MDC rises at edge k + b*N + h and falls at edge k + (b+1)*N.
- The bit for bit time b is on MDIO from edge k + b*N.
- idle, and read data in the register, are due at edge k + 64*N.
- An abort shows one edge after mgmt_en drops.

The bench counts cycles from the accepting edge and checks mdc, mdio_oe, mdio_out and idle on every falling clock edge of the frame, against values it computes from the cycle index and the divisor. It drives MDIO data during the low half of MDC, so each value is settled before the rising edge that samples it. The register is checked on the first falling clock edge after edge k + 64*N.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int DIV_MIN = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        mgmt_en,
  input  logic [1:0]  div_sel,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in,
  output logic        idle
);
  localparam int HALF_MAX = DIV_MIN * 4;
  localparam int CW       = $clog2(HALF_MAX);
  localparam int TOTAL    = PRE_LEN + 32;
  localparam int BW       = $clog2(TOTAL + 1);
  localparam int RD_REL   = PRE_LEN + 15;
  localparam int RD_CAP   = PRE_LEN + 16;

  logic [31:0]   cmd_q;
  logic          busy, mdc_q, rd_q;
  logic [1:0]    div_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;

  wire [CW-1:0] half_m1  = CW'(((DIV_MIN / 2) << div_q) - 1);
  wire          tick     = busy && (cnt == half_m1);
  wire          in_frame = bitn >= BW'(PRE_LEN);
  wire [4:0]    fidx     = 5'(bitn - BW'(PRE_LEN));
  wire          start    = cmd_wr && mgmt_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      busy  <= 1'b0;
      mdc_q <= 1'b0;
      rd_q  <= 1'b0;
      div_q <= '0;
      cnt   <= '0;
      bitn  <= '0;
    end else if (start) begin
      cmd_q <= cmd_wdata;
      busy  <= 1'b1;
      rd_q  <= (cmd_wdata[29:28] == 2'b10);
      div_q <= div_sel;
      cnt   <= '0;
      bitn  <= '0;
      mdc_q <= 1'b0;
    end else if (busy && !mgmt_en) begin
      busy  <= 1'b0;
      mdc_q <= 1'b0;
      cnt   <= '0;
    end else if (tick) begin
      cnt   <= '0;
      mdc_q <= !mdc_q;
      if (mdc_q) begin
        if (bitn == BW'(TOTAL - 1)) busy <= 1'b0;
        else bitn <= bitn + BW'(1);
      end else if (rd_q && bitn >= BW'(RD_CAP)) begin
        cmd_q[15:0] <= {cmd_q[14:0], mdio_in};
      end
    end else if (busy) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign cmd_rdata = cmd_q;
  assign mdc       = mdc_q;
  assign idle      = !busy;
  assign mdio_oe   = busy && !(rd_q && bitn >= BW'(RD_REL));
  assign mdio_out  = busy && (!in_frame || cmd_q[5'd31 - fidx]);
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        mgmt_en,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        idle
);
  assert_idle_mdc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdc);

  assert_start_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mgmt_en && cmd_wr) |=> (!idle && !mdc && mdio_oe && mdio_out));

  assert_hdr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cmd_rdata[31:16]));

  assert_disabled_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !mgmt_en) |=> idle);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !mgmt_en) |=> (idle && !mdio_oe && !mdc));

  assert_write_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd_rdata[29:28] != 2'b10) |-> mdio_oe);

  assert_mdc_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(!mdc, 3));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .mgmt_en(mgmt_en),
  .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_out(mdio_out),
  .mdio_oe(mdio_oe), .idle(idle)
);

// File: tb/tb_mdio_frame_ctrl.sv
module tb_mdio_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        mgmt_en = 1'b1;
  logic [1:0]  div_sel = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_out, mdio_oe, idle;
  logic        mdio_in = 1'b0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mdio_frame_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .mgmt_en(mgmt_en), .div_sel(div_sel), .cmd_rdata(cmd_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [31:0] cmd, input logic [1:0] sel,
                           input logic [15:0] rpat, input bit poke_busy, input bit poke_sel);
    int n = 8 << sel;
    int h = n / 2;
    bit rd = (cmd[29:28] == 2'b10);
    logic [31:0] exp_reg;
    @(negedge clk);
    div_sel = sel; cmd_wdata = cmd; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    for (int j = 0; j < 64 * n; j++) begin
      int b = j / n;
      int ph = j % n;
      chk(mdc == (ph >= h), "R3", {31'd0, mdc}, {31'd0, ph >= h});
      chk(idle == 1'b0, "R8", {31'd0, idle}, 32'd0);
      if (b < 32) begin
        chk(mdio_oe && mdio_out, "R4", {30'd0, mdio_oe, mdio_out}, 32'd3);
      end else begin
        int fi = b - 32;
        bit eoe = !(rd && fi >= 15);
        chk(mdio_oe == eoe, "R6", {31'd0, mdio_oe}, {31'd0, eoe});
        if (eoe) chk(mdio_out == cmd[31 - fi], "R5", {31'd0, mdio_out}, {31'd0, cmd[31 - fi]});
        if (rd && fi >= 16 && ph == 0) mdio_in = rpat[15 - (fi - 16)];
      end
      if (poke_busy && j == 3 * n) begin cmd_wdata = ~cmd; cmd_wr = 1'b1; end
      if (poke_busy && j == 3 * n + 1) cmd_wr = 1'b0;
      if (poke_sel && j == 5) div_sel = ~sel;
      @(negedge clk);
    end
    exp_reg = rd ? {cmd[31:16], rpat} : cmd;
    chk(idle == 1'b1, "R8", {31'd0, idle}, 32'd1);
    chk(!mdio_oe && !mdc, "R8", {30'd0, mdio_oe, mdc}, 32'd0);
    chk(cmd_rdata == exp_reg, rd ? "R7" : "R2", cmd_rdata, exp_reg);
    if (poke_busy) chk(cmd_rdata == exp_reg, "R9", cmd_rdata, exp_reg);
    if (poke_sel) chk(cmd_rdata == exp_reg, "R11", cmd_rdata, exp_reg);
    div_sel = sel;
    mdio_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1", {31'd0, idle}, 32'd1);
    chk(!mdc && !mdio_oe, "R1", {30'd0, mdc, mdio_oe}, 32'd0);
    chk(cmd_rdata == 32'd0, "R1", cmd_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      logic [4:0] pa = 5'(3 + 7 * s);
      logic [4:0] ra = 5'(30 - 5 * s);
      logic [15:0] wd = 16'hA5C3 ^ 16'(s * 16'h1111);
      logic [15:0] rp = 16'h8001 ^ 16'(s * 16'h0F0F);
      run_frame({2'b01, 2'b01, pa, ra, 2'b10, wd}, 2'(s), 16'h0, 1'b0, 1'b0);
      run_frame({2'b01, 2'b10, pa, ra, 2'b10, 16'h0000}, 2'(s), rp, 1'b0, 1'b0);
    end

    // R9 write while busy, R11 divisor change mid-frame
    run_frame({2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'h0}, 2'd0, 16'h3CA5, 1'b1, 1'b0);
    run_frame({2'b01, 2'b01, 5'd9, 5'd12, 2'b10, 16'h7E81}, 2'd1, 16'h0, 1'b0, 1'b1);

    // R10 abort mid-frame
    @(negedge clk);
    div_sel = 2'd0; cmd_wdata = 32'h5A5A_1234; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk(idle == 1'b0, "R10", {31'd0, idle}, 32'd0);
    mgmt_en = 1'b0;
    @(negedge clk);
    chk(idle && !mdio_oe && !mdc, "R10", {29'd0, idle, mdio_oe, mdc}, 32'd4);

    // R10 write ignored while disabled
    hold = cmd_rdata;
    cmd_wdata = 32'h6000_FFFF; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(idle == 1'b1, "R10", {31'd0, idle}, 32'd1);
    chk(!mdio_oe && !mdc, "R10", {30'd0, mdio_oe, mdc}, 32'd0);
    chk(cmd_rdata == hold, "R10", cmd_rdata, hold);
    mgmt_en = 1'b1;

    // a frame starts normally after re-enable
    run_frame({2'b01, 2'b10, 5'd31, 5'd0, 2'b10, 16'h0}, 2'd3, 16'hFFFF, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule